// File: doc/BRIEF.md
# SDRAM Byte-Mask Pipeline

This block sits between a memory controller's data path and the data and byte-mask pins of a 16-bit SDRAM. It covers two byte lanes. Each lane has a mask bit, and the write and read directions handle that bit with different timing. On a write, the controller's data goes to the DQ pins with the output enable raised, and the write mask goes to the mask pins in the same cycle. On a read, the device applies the mask two clocks after it registers it. The returned beat itself appears CAS_LAT clocks after the controller announces the read slot. The block therefore holds the read mask back by CAS_LAT-2 clocks before it drives the mask pins.

The block also keeps a record of the mask value the pins really carried for two more clocks. It uses that record to qualify each returned byte. The read capture stage reports every read slot as a beat, including slots whose lanes were all masked, so that the controller's beat count stays aligned. A lane is valid only when its pin mask was low. Data bytes on masked lanes are forced to zero. A write always takes the mask pins, even in a cycle where a delayed read mask is also due. That read beat is then qualified by the mask the pins carried, because that is the mask the device acted on.

Top module: `sdr_dqm_lane_pipe`

## Requirements
- R1: While rst_ni is low and after its release, with no traffic, dqm_o is all ones, dq_oe_o is zero, and rd_beat_o, rd_valid_o and rd_data_o are zero.
- R2: In a cycle with wr_en_i high, dq_oe_o is high on every lane and dq_o equals wr_data_i in that cycle, whatever the mask. With wr_en_i low, dq_oe_o is zero.
- R3: In a cycle with wr_en_i high, dqm_o equals wr_mask_i in that cycle. Bit l governs lane l, which is data bits [8l+7:8l], and 1 means masked.
- R4: A read slot (rd_en_i high with rd_mask_i) in cycle n drives dqm_o to rd_mask_i in cycle n+CAS_LAT-2, provided that cycle has no write. When there is neither a write nor a due read mask, dqm_o is all ones.
- R5: Every read slot in cycle n gives rd_beat_o high in cycle n+CAS_LAT+1, including slots whose lanes are all masked. rd_valid_o is never high without rd_beat_o.
- R6: A lane of a beat is valid, and its rd_data_o byte equals the dq_i byte sampled in cycle n+CAS_LAT, when dqm_o for that lane was low in cycle n+CAS_LAT-2.
- R7: A lane whose pin mask was high two cycles before its data landed has rd_valid_o low and a zero rd_data_o byte, whatever dq_i carried.
- R8: A write in the same cycle as a due read mask takes dqm_o. The read beat's lane validity then follows the write mask that the pins carried.
- R9: Read slots in consecutive cycles give consecutive beats, each with its own mask and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write data cycle |
| wr_data_i | input | 16 | Write data for this cycle |
| wr_mask_i | input | 2 | Write byte mask, 1 = lane not written |
| rd_en_i | input | 1 | Read slot announced this cycle |
| rd_mask_i | input | 2 | Read byte mask for this slot, 1 = lane suppressed |
| dq_i | input | 16 | Data sampled from the DQ pads |
| dq_o | output | 16 | Data driven to the DQ pads |
| dq_oe_o | output | 2 | Per-lane pad output enable |
| dqm_o | output | 2 | Byte-mask pins |
| rd_beat_o | output | 1 | A read beat is reported this cycle |
| rd_valid_o | output | 2 | Per-lane valid for the reported beat |
| rd_data_o | output | 16 | Read data, masked lanes zeroed |

## Verification
The hardest case to reach is a write whose mask lands on the same pin cycle as a delayed read mask. The read slot has to be announced exactly CAS_LAT-2 cycles before the write, and the two masks must differ so that the choice of winner can be seen in the lane validity three cycles later. The bench sets this up with a directed sequence: a read slot, then a write at that offset with the opposite mask. It then runs a pseudo-random mix of overlapping reads and writes. A bench-side device model acts on the mask pins it actually observed two cycles earlier. It drives a recognisable pattern on unmasked lanes and a junk byte on masked ones, so that a lane the block fails to gate shows up at the read data port.

// File: rtl/sdr_dqm_pkg.sv
package sdr_dqm_pkg;
  localparam int unsigned LANE_W_DEF  = 8;
  localparam int unsigned LANES_DEF   = 2;
  localparam int unsigned CAS_LAT_DEF = 3;
  // device applies a read mask this many clocks after registering it
  localparam int unsigned DQM_RD_LAG  = 2;
endpackage

// File: rtl/dqm_stage_delay.sv
module dqm_stage_delay #(
  parameter int unsigned LANES = 2,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_i,
  input  logic [LANES-1:0] mask_i,
  output logic             slot_o,
  output logic [LANES-1:0] mask_o
);
  generate
    if (DEPTH == 0) begin : g_thru
      assign slot_o = slot_i;
      assign mask_o = mask_i;
    end else begin : g_pipe
      logic [DEPTH-1:0] slot_q;
      logic [LANES-1:0] mask_q [DEPTH];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          slot_q <= '0;
          for (int k = 0; k < DEPTH; k++) mask_q[k] <= '1;
        end else begin
          for (int k = DEPTH - 1; k > 0; k--) begin
            slot_q[k] <= slot_q[k-1];
            mask_q[k] <= mask_q[k-1];
          end
          slot_q[0] <= slot_i;
          mask_q[0] <= mask_i;
        end
      end

      assign slot_o = slot_q[DEPTH-1];
      assign mask_o = mask_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/dq_write_drive.sv
module dq_write_drive #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [LANES-1:0] wr_mask_i,
  input  logic             tap_slot_i,
  input  logic [LANES-1:0] tap_mask_i,
  output logic [DW-1:0]    dq_o,
  output logic [LANES-1:0] dq_oe_o,
  output logic [LANES-1:0] dqm_o
);
  // masked write lanes stay driven: device ignores them
  assign dq_o    = wr_data_i;
  assign dq_oe_o = {LANES{wr_en_i}};

  always_comb begin
    if (wr_en_i)         dqm_o = wr_mask_i;
    else if (tap_slot_i) dqm_o = tap_mask_i;
    else                 dqm_o = '1;
  end
endmodule

// File: rtl/dq_read_capture.sv
module dq_read_capture #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             land_slot_i,
  input  logic [LANES-1:0] land_mask_i,
  input  logic [DW-1:0]    dq_i,
  output logic             rd_beat_o,
  output logic [LANES-1:0] rd_valid_o,
  output logic [DW-1:0]    rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_beat_o <= 1'b0;
    else         rd_beat_o <= land_slot_i;
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic lane_ok;
      assign lane_ok = land_slot_i & ~land_mask_i[l];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rd_valid_o[l]                    <= 1'b0;
          rd_data_o[l*LANE_W +: LANE_W]    <= '0;
        end else begin
          rd_valid_o[l]                    <= lane_ok;
          rd_data_o[l*LANE_W +: LANE_W]    <= lane_ok ? dq_i[l*LANE_W +: LANE_W] : '0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sdr_dqm_lane_pipe.sv
module sdr_dqm_lane_pipe
  import sdr_dqm_pkg::*;
#(
  parameter int unsigned LANES   = LANES_DEF,
  parameter int unsigned LANE_W  = LANE_W_DEF,
  parameter int unsigned CAS_LAT = CAS_LAT_DEF,
  localparam int unsigned DW     = LANES * LANE_W,
  localparam int unsigned PRE_D  = CAS_LAT - DQM_RD_LAG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [LANES-1:0] wr_mask_i,
  input  logic             rd_en_i,
  input  logic [LANES-1:0] rd_mask_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic [LANES-1:0] dq_oe_o,
  output logic [LANES-1:0] dqm_o,
  output logic             rd_beat_o,
  output logic [LANES-1:0] rd_valid_o,
  output logic [DW-1:0]    rd_data_o
);
  logic             tap_slot, land_slot;
  logic [LANES-1:0] tap_mask, land_mask;

  // hold read mask so the device lag ends on the data beat
  dqm_stage_delay #(.LANES(LANES), .DEPTH(PRE_D)) u_issue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_i (rd_en_i),
    .mask_i (rd_mask_i),
    .slot_o (tap_slot),
    .mask_o (tap_mask)
  );

  dq_write_drive #(.LANES(LANES), .LANE_W(LANE_W)) u_drive (
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .wr_mask_i  (wr_mask_i),
    .tap_slot_i (tap_slot),
    .tap_mask_i (tap_mask),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o),
    .dqm_o      (dqm_o)
  );

  // track what the pins carried, not what was requested
  dqm_stage_delay #(.LANES(LANES), .DEPTH(DQM_RD_LAG)) u_return (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_i (tap_slot),
    .mask_i (dqm_o),
    .slot_o (land_slot),
    .mask_o (land_mask)
  );

  dq_read_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .land_slot_i (land_slot),
    .land_mask_i (land_mask),
    .dq_i        (dq_i),
    .rd_beat_o   (rd_beat_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/sdr_dqm_lane_pipe_chk.sv
module sdr_dqm_lane_pipe_chk #(
  parameter int unsigned LANES   = 2,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned CAS_LAT = 3,
  localparam int unsigned DW     = LANES * LANE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [LANES-1:0] wr_mask_i,
  input logic             rd_en_i,
  input logic [LANES-1:0] dqm_o,
  input logic             rd_beat_o,
  input logic [LANES-1:0] rd_valid_o,
  input logic [DW-1:0]    rd_data_o
);
  AST_WRITE_MASK_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> dqm_o == wr_mask_i); // R3

  AST_BEAT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_beat_o == $past(rd_en_i, CAS_LAT + 1)); // R5

  AST_VALID_NEEDS_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_valid_o) |-> rd_beat_o); // R5

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      AST_VALID_NEEDS_LOW_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o[l] |-> !$past(dqm_o[l], 3)); // R6

      AST_MASKED_LANE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_valid_o[l] |-> rd_data_o[l*LANE_W +: LANE_W] == '0); // R7
    end
  endgenerate
endmodule

bind sdr_dqm_lane_pipe sdr_dqm_lane_pipe_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .CAS_LAT(CAS_LAT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_mask_i  (wr_mask_i),
  .rd_en_i    (rd_en_i),
  .dqm_o      (dqm_o),
  .rd_beat_o  (rd_beat_o),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/sim_sdr_dqm_lane_pipe.sv
module sim_sdr_dqm_lane_pipe;
  localparam int CL = 3;
  localparam int HN = 2048;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  wr_mask_i = '0;
  logic        rd_en_i = 1'b0;
  logic [1:0]  rd_mask_i = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe_o;
  logic [1:0]  dqm_o;
  logic        rd_beat_o;
  logic [1:0]  rd_valid_o;
  logic [15:0] rd_data_o;

  always #10 clk = ~clk;

  sdr_dqm_lane_pipe #(.LANES(2), .LANE_W(8), .CAS_LAT(CL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .wr_mask_i(wr_mask_i), .rd_en_i(rd_en_i), .rd_mask_i(rd_mask_i), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dqm_o(dqm_o), .rd_beat_o(rd_beat_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  logic       h_rd  [HN];
  logic [1:0] h_rm  [HN];
  logic       h_wr  [HN];
  logic [1:0] h_exp [HN];
  logic [1:0] h_obs [HN];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [15:0] pat(int c);
    return 16'(c * 32'h1357 + 32'h02A1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic step(logic rst, logic wr, logic [15:0] wd, logic [1:0] wm,
                      logic rd, logic [1:0] rm);
    logic [1:0]  e_dqm, e_val;
    logic [15:0] e_dat, dev;
    logic        tap, beat;
    int          k;
    string       tag;
    @(negedge clk);
    rst_ni = rst; wr_en_i = wr; wr_data_i = wd; wr_mask_i = wm;
    rd_en_i = rd; rd_mask_i = rm;
    h_rd[cyc] = rd; h_rm[cyc] = rm; h_wr[cyc] = wr;
    tap = (cyc >= CL - 2) && h_rd[cyc-(CL-2)];
    e_dqm = wr ? wm : (tap ? h_rm[cyc-(CL-2)] : 2'b11);
    h_exp[cyc] = e_dqm;
    // device model: acts on pin mask it saw two cycles earlier, junk when masked
    dev = 16'hEEEE;
    if (cyc >= CL && h_rd[cyc-CL]) begin
      for (int l = 0; l < 2; l++)
        if (!h_obs[cyc-2][l]) dev[l*8 +: 8] = pat(cyc)[l*8 +: 8];
    end
    dq_i = dev;
    #5;
    if (!rst) begin
      check("R1 dqm", 32'(dqm_o), 32'h3);
      check("R1 oe", 32'(dq_oe_o), 32'h0);
      check("R1 beat", 32'(rd_beat_o), 32'h0);
      check("R1 valid", 32'(rd_valid_o), 32'h0);
      check("R1 data", 32'(rd_data_o), 32'h0);
    end else begin
      tag = wr && tap ? "R8 dqm" : (wr ? "R3 dqm" : "R4 dqm");
      check(tag, 32'(dqm_o), 32'(e_dqm));
      check("R2 oe", 32'(dq_oe_o), wr ? 32'h3 : 32'h0);
      if (wr) check("R2 dq", 32'(dq_o), 32'(wd));
      k = cyc - CL - 1;
      beat = (k >= 0) && h_rd[k];
      e_val = 2'b00; e_dat = '0;
      if (beat) begin
        for (int l = 0; l < 2; l++)
          if (!h_exp[cyc-3][l]) begin
            e_val[l] = 1'b1;
            e_dat[l*8 +: 8] = pat(cyc-1)[l*8 +: 8];
          end
      end
      tag = (beat && k > 0 && h_rd[k-1]) ? "R9 beat" : "R5 beat";
      check(tag, 32'(rd_beat_o), 32'(beat));
      if (beat && h_wr[cyc-3])     tag = "R8 lanes";
      else if (e_val != 2'b11)     tag = "R7 lanes";
      else                         tag = "R6 lanes";
      check({tag, " valid"}, 32'(rd_valid_o), 32'(e_val));
      check({tag, " data"}, 32'(rd_data_o), 32'(e_dat));
    end
    h_obs[cyc] = dqm_o;
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 0, '0, '0, 0, '0);
  endtask

  initial begin
    int unsigned lcg;
    for (int i = 0; i < HN; i++) begin
      h_rd[i] = 0; h_rm[i] = '0; h_wr[i] = 0; h_exp[i] = 2'b11; h_obs[i] = 2'b11;
    end
    // R1 reset state
    for (int i = 0; i < 3; i++) step(0, 0, '0, '0, 0, '0);
    idle(3);
    // R2 R3 writes with every mask
    step(1, 1, 16'hA55A, 2'b00, 0, '0);
    step(1, 1, 16'h1234, 2'b01, 0, '0);
    step(1, 1, 16'hBEEF, 2'b10, 0, '0);
    step(1, 1, 16'h0F0F, 2'b11, 0, '0);
    idle(3);
    // R4 R6 R7 single read slots
    for (int m = 0; m < 4; m++) begin
      step(1, 0, '0, '0, 1, 2'(m));
      idle(6);
    end
    // R9 back-to-back slots
    for (int i = 0; i < 8; i++) step(1, 0, '0, '0, 1, 2'(i));
    idle(6);
    // R8 write lands on the due read mask
    step(1, 0, '0, '0, 1, 2'b01);
    for (int i = 0; i < CL - 3; i++) idle(1);
    step(1, 1, 16'hC3C3, 2'b10, 0, '0);
    idle(6);
    step(1, 0, '0, '0, 1, 2'b11);
    for (int i = 0; i < CL - 3; i++) idle(1);
    step(1, 1, 16'h3C3C, 2'b00, 0, '0);
    idle(6);
    // mixed traffic
    lcg = 32'h1F2E3D4C;
    for (int i = 0; i < 150; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      step(1, lcg[20], 16'(lcg >> 8), lcg[23:22], lcg[25] | lcg[26], lcg[29:28]);
    end
    idle(8);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule